// File: doc/BRIEF.md
# Read data capture and valid generator

This block sits on the read side of a controller for a synchronous SRAM that has separate read and write data channels, each running at double data rate. Data beats return from the memory twice per memory clock. Each cycle they appear on two half-cycle lanes: an early lane for the beat at the rising edge and a late lane for the beat at the falling edge. The block collects the beats of each burst (2 or 4 beats of 8, 9 or 18 bits) into one wide user word and holds the words in a small in-order queue. A user read strobe takes words from that queue.

A build parameter chooses where beat validity comes from. In memory-valid mode, two per-lane valid inputs driven by the memory qualify each beat, and the read-issue and latency inputs are not used. In generated-valid mode, the block records every issued read and predicts when its data returns. The prediction uses a programmed latency: a whole-cycle (coarse) part plus an optional half-cycle (fine) step. This covers read latencies of 1, 1.5, 2 and 2.5 memory cycles. The predicted valid window is exactly one burst long.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the core leaves reset on the second rising clock edge after release.

Top module: `sram_rd_capture`

## Requirements
- R1: While reset is held and after it is released with no beats captured, `rd_ready` is 0.
- R2: In generated-valid mode, a read issued in cycle n has its first beat in half-slot 2n+L, where L = 2*`lat_coarse` + `lat_fine`. Half-slot 2m is the early lane of cycle m and 2m+1 is the late lane. Coarse values 1 and 2 with fine 0 or 1 give latencies of 1, 1.5, 2 and 2.5 cycles.
- R3: Beat k of a burst (k = 0 first) lands in bits [k*BW +: BW] of the user word. Within one cycle, the early-lane beat comes before the late-lane beat.
- R4: In generated-valid mode, exactly BL consecutive half-slots starting at the predicted slot are captured. Lane contents outside that window, and the memory-valid inputs, have no effect on the words.
- R5: In memory-valid mode, a lane's beat is captured if and only if its valid input is 1. The read-issue and latency inputs have no effect.
- R6: In memory-valid mode, a read whose valid inputs never arrive produces no word, and `rd_ready` stays 0.
- R7: `rd_ready` rises after the clock edge that samples the last beat of a burst into an empty queue, and not before it.
- R8: Up to QDEPTH completed words are held and delivered in completion order, including bursts whose beats arrive back to back.
- R9: While `rd_ready` is 1 and `rd_en_n` is 1, the head word stays on `rd_data`. A clock edge with `rd_en_n` low and `rd_ready` high removes it. The queue reads as empty once every word has been taken.
- R10: A word that completes while QDEPTH words are queued and none is taken in that cycle is discarded. The queued words are kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_issue | input | 1 | A read is issued to the memory this cycle |
| lat_coarse | input | CW | Read latency, whole cycles |
| lat_fine | input | 1 | Adds one half cycle to the read latency |
| beat_lo | input | BW | Beat returned at the rising edge (early lane) |
| beat_hi | input | BW | Beat returned at the falling edge (late lane) |
| mvld_lo | input | 1 | Memory valid for the early lane |
| mvld_hi | input | 1 | Memory valid for the late lane |
| rd_en_n | input | 1 | Active-low user read strobe |
| rd_ready | output | 1 | A user word is available |
| rd_data | output | BL*BW | Head user word, beat 0 in the low bits |

## Verification
Two copies of the block are run side by side on the same beat stream. One generates valid from its issue record. The other has its issue input tied low and a deliberately wrong latency, and relies only on the memory valid lines. The stream is swept over all four latencies. For each latency it uses a lone read (which pins the exact cycle in which `rd_ready` rises), reads spaced 2, 3 and 5 cycles apart, and a five-read run into a four-word queue. Contiguous beats from two-cycle spacing would expose a burst boundary slipping by one half-slot, while the wider gaps put garbage next to each window. The queue overflow, and one read whose memory valid is withheld, separate the discard rule and the missing-valid rule from ordinary capture.

// File: rtl/sram_rdcap_pkg.sv
package sram_rdcap_pkg;

  // Read latency in half memory cycles from its coarse and fine parts.
  function automatic int lat_halves(input int coarse, input bit fine);
    return 2 * coarse + (fine ? 1 : 0);
  endfunction

  typedef struct packed {
    logic lo;
    logic hi;
  } lane_vld_t;

endpackage

// File: rtl/sram_rdcap_vgen.sv
module sram_rdcap_vgen
  import sram_rdcap_pkg::*;
#(
  parameter int BL = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [CW-1:0] coarse,
  input  logic          fine,
  output lane_vld_t     vld
);
  localparam int CMAX = (1 << CW) - 1;
  localparam int LMAX = 2 * CMAX + 1;
  localparam int HD   = (LMAX + BL - 1) / 2 + 1;
  localparam int IW   = (HD > 2) ? $clog2(HD) : 1;

  // hist_q[j] : a read was issued j cycles before the current one
  logic [HD-1:1] hist_q;
  logic [HD-1:1] hist_d;
  logic [HD-1:0] hist_all;

  assign hist_all = {hist_q, issue};

  always_comb begin
    hist_d = hist_all[HD-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    int lat;
    vld = '0;
    lat = lat_halves(int'(coarse), fine);
    for (int b = 0; b < BL; b++) begin
      int k;
      k = lat + b;
      if (k[0] == 1'b0) vld.lo = vld.lo | hist_all[IW'(k >> 1)];
      else              vld.hi = vld.hi | hist_all[IW'(k >> 1)];
    end
  end

endmodule

// File: rtl/sram_rdcap_pack.sv
module sram_rdcap_pack
  import sram_rdcap_pkg::*;
#(
  parameter int BW = 9,
  parameter int BL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_vld_t        vld,
  input  logic [BW-1:0]    beat_lo,
  input  logic [BW-1:0]    beat_hi,
  output logic             push,
  output logic [BL*BW-1:0] word
);
  localparam int CNTW = $clog2(BL);

  logic [BL-1:0][BW-1:0] buf_q, buf_n;
  logic [CNTW-1:0]       cnt_q, cnt_n;
  logic                  upd;

  always_comb begin
    buf_n = buf_q;
    cnt_n = cnt_q;
    push  = 1'b0;
    word  = '0;
    if (vld.lo) begin
      buf_n[cnt_n] = beat_lo;
      if (cnt_n == CNTW'(BL - 1)) begin
        push  = 1'b1;
        word  = buf_n;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_n + 1'b1;
      end
    end
    if (vld.hi) begin
      buf_n[cnt_n] = beat_hi;
      if (cnt_n == CNTW'(BL - 1)) begin
        push  = 1'b1;
        word  = buf_n;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_n + 1'b1;
      end
    end
  end

  assign upd = vld.lo | vld.hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      buf_q <= buf_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/sram_rdcap_fifo.sv
module sram_rdcap_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       not_empty,
  output logic [$clog2(DEPTH):0]     level
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop & (cnt_q != '0);
  assign push_ok = push & ((cnt_q != (AW+1)'(DEPTH)) | pop_ok);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = wr_q + 1'b1;
    if (pop_ok)  rd_d = rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= din;
  end

  assign dout      = mem_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign level     = cnt_q;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
  import sram_rdcap_pkg::*;
#(
  parameter int BW            = 18,
  parameter int BL            = 4,
  parameter int CW            = 2,
  parameter int QDEPTH        = 4,
  parameter bit USE_MEM_VALID = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_issue,
  input  logic [CW-1:0]    lat_coarse,
  input  logic             lat_fine,
  input  logic [BW-1:0]    beat_lo,
  input  logic [BW-1:0]    beat_hi,
  input  logic             mvld_lo,
  input  logic             mvld_hi,
  input  logic             rd_en_n,
  output logic             rd_ready,
  output logic [BL*BW-1:0] rd_data
);
  localparam int DW = BL * BW;
  localparam int LW = $clog2(QDEPTH) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  lane_vld_t     lane_vld;
  logic          q_push;
  logic [DW-1:0] q_word;
  logic          q_pop;
  logic [LW-1:0] q_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  generate
    if (USE_MEM_VALID) begin : g_mem_vld
      logic unused_cfg;
      assign unused_cfg  = ^{rd_issue, lat_coarse, lat_fine};
      assign lane_vld.lo = mvld_lo;
      assign lane_vld.hi = mvld_hi;
    end else begin : g_gen_vld
      logic unused_mvld;
      assign unused_mvld = mvld_lo ^ mvld_hi;
      sram_rdcap_vgen #(.BL(BL), .CW(CW)) u_vgen (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .issue  (rd_issue),
        .coarse (lat_coarse),
        .fine   (lat_fine),
        .vld    (lane_vld)
      );
    end
  endgenerate

  sram_rdcap_pack #(.BW(BW), .BL(BL)) u_pack (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .vld     (lane_vld),
    .beat_lo (beat_lo),
    .beat_hi (beat_hi),
    .push    (q_push),
    .word    (q_word)
  );

  assign q_pop = ~rd_en_n;

  sram_rdcap_fifo #(.W(DW), .DEPTH(QDEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (q_push),
    .din       (q_word),
    .pop       (q_pop),
    .dout      (rd_data),
    .not_empty (rd_ready),
    .level     (q_level)
  );

endmodule

// File: rtl/sram_rd_capture_chk.sv
module sram_rd_capture_chk #(
  parameter int DW    = 36,
  parameter int DEPTH = 4,
  parameter bit MEM_V = 1'b0,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en_n,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          mvld_lo,
  input logic          mvld_hi,
  input logic          q_push,
  input logic [LW-1:0] q_level
);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LW'(DEPTH));

  assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && rd_en_n) |=> (rd_ready && $stable(rd_data)));

  assert_pop_drops_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_en_n && !q_push) |=> (q_level == $past(q_level) - 1'b1));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && rd_en_n && q_level == LW'(DEPTH)) |=> (q_level == LW'(DEPTH)));

  assert_no_word_without_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (MEM_V && !mvld_lo && !mvld_hi) |-> !q_push);

endmodule

bind sram_rd_capture sram_rd_capture_chk #(
  .DW(BL*BW), .DEPTH(QDEPTH), .MEM_V(USE_MEM_VALID), .LW($clog2(QDEPTH)+1)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .rd_en_n  (rd_en_n),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .mvld_lo  (mvld_lo),
  .mvld_hi  (mvld_hi),
  .q_push   (q_push),
  .q_level  (q_level)
);

// File: tb/sim_sram_rd_capture.sv
`timescale 1ns/1ps
module sim_sram_rd_capture;
  localparam int BW = 9;
  localparam int BL = 4;
  localparam int CW = 2;
  localparam int QD = 4;
  localparam int DW = BW * BL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_issue = 1'b0;
  logic [CW-1:0] lat_coarse = 2'd1;
  logic lat_fine = 1'b0;
  logic [BW-1:0] beat_lo = '0, beat_hi = '0;
  logic mvld_lo = 1'b0, mvld_hi = 1'b0;
  logic rd_en_n0 = 1'b1, rd_en_n1 = 1'b1;
  logic rd_ready0, rd_ready1;
  logic [DW-1:0] rd_data0, rd_data1;

  always #5 clk = ~clk;

  // u0: generated valid from the issue record
  sram_rd_capture #(.BW(BW), .BL(BL), .CW(CW), .QDEPTH(QD), .USE_MEM_VALID(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .lat_coarse(lat_coarse),
    .lat_fine(lat_fine), .beat_lo(beat_lo), .beat_hi(beat_hi),
    .mvld_lo(mvld_lo), .mvld_hi(mvld_hi), .rd_en_n(rd_en_n0),
    .rd_ready(rd_ready0), .rd_data(rd_data0));

  // u1: memory valid only; issue tied low and latency set wrong on purpose (R5)
  sram_rd_capture #(.BW(BW), .BL(BL), .CW(CW), .QDEPTH(QD), .USE_MEM_VALID(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .rd_issue(1'b0), .lat_coarse(2'd3),
    .lat_fine(1'b1), .beat_lo(beat_lo), .beat_hi(beat_hi),
    .mvld_lo(mvld_lo), .mvld_hi(mvld_hi), .rd_en_n(rd_en_n1),
    .rd_ready(rd_ready1), .rd_data(rd_data1));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rdno = 0;
  bit done = 1'b0;

  logic [BW-1:0] sd_lo [64];
  logic [BW-1:0] sd_hi [64];
  bit sv_lo [64];
  bit sv_hi [64];
  bit sm_lo [64];
  bit sm_hi [64];

  logic [DW-1:0] exp0 [$];
  logic [DW-1:0] exp1 [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [BW-1:0] beatval(input int k, input int b);
    return BW'(k * 37 + b * 11 + 5);
  endfunction

  function automatic logic [BW-1:0] junk(input int n, input int h);
    return BW'(n * 53 + h * 29 + 7) ^ BW'(9'h155);
  endfunction

  // Place the beats of a read issued in cycle n into the half-slot schedule.
  task automatic schedule(input int n, input bit sup);
    int L;
    logic [DW-1:0] w;
    L = 2 * int'(lat_coarse) + int'(lat_fine);
    w = '0;
    for (int b = 0; b < BL; b++) begin
      int s, c, idx;
      s = L + b;
      c = n + s / 2;
      idx = c % 64;
      w[b*BW +: BW] = beatval(rdno, b);
      if (s % 2 == 0) begin
        sd_lo[idx] = beatval(rdno, b); sv_lo[idx] = 1'b1; sm_lo[idx] = !sup;
      end else begin
        sd_hi[idx] = beatval(rdno, b); sv_hi[idx] = 1'b1; sm_hi[idx] = !sup;
      end
    end
    if (exp0.size() < QD) exp0.push_back(w);
    if (!sup && exp1.size() < QD) exp1.push_back(w);
    rdno++;
  endtask

  // Drive the inputs for the next cycle, let its rising edge pass, return at the falling edge.
  task automatic step(input bit iss, input bit sup);
    int n, idx;
    n = cyc + 1;
    if (iss) schedule(n, sup);
    idx = n % 64;
    rd_issue = iss;
    beat_lo = sv_lo[idx] ? sd_lo[idx] : junk(n, 0);
    beat_hi = sv_hi[idx] ? sd_hi[idx] : junk(n, 1);
    mvld_lo = sm_lo[idx];
    mvld_hi = sm_hi[idx];
    sv_lo[idx] = 1'b0; sv_hi[idx] = 1'b0;
    sm_lo[idx] = 1'b0; sm_hi[idx] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cyc = n;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0);
  endtask

  task automatic drain();
    int n;
    n = (exp0.size() > exp1.size()) ? exp0.size() : exp1.size();
    for (int i = 0; i < n; i++) begin
      bit p0, p1;
      p0 = exp0.size() > 0;
      p1 = exp1.size() > 0;
      if (p0) begin
        chk(rd_ready0 == 1'b1, "R8 u0 ready", 64'(rd_ready0), 64'd1);
        chk(rd_data0 == exp0[0], "R3 u0 word", 64'(rd_data0), 64'(exp0[0]));
      end
      if (p1) begin
        chk(rd_ready1 == 1'b1, "R8 u1 ready", 64'(rd_ready1), 64'd1);
        chk(rd_data1 == exp1[0], "R5 u1 word", 64'(rd_data1), 64'(exp1[0]));
      end
      if (i == 0) begin
        idle(1);
        if (p0) chk(rd_data0 == exp0[0], "R9 u0 hold", 64'(rd_data0), 64'(exp0[0]));
        if (p1) chk(rd_data1 == exp1[0], "R9 u1 hold", 64'(rd_data1), 64'(exp1[0]));
      end
      rd_en_n0 = !p0;
      rd_en_n1 = !p1;
      step(1'b0, 1'b0);
      rd_en_n0 = 1'b1;
      rd_en_n1 = 1'b1;
      if (p0) void'(exp0.pop_front());
      if (p1) void'(exp1.pop_front());
    end
    chk(rd_ready0 == 1'b0, "R9 u0 empty", 64'(rd_ready0), 64'd0);
    chk(rd_ready1 == 1'b0, "R9 u1 empty", 64'(rd_ready1), 64'd0);
  endtask

  task automatic run_reads(input int count, input int gap, input bit sup);
    for (int i = 0; i < count; i++) begin
      step(1'b1, sup);
      idle(gap - 1);
    end
    idle(8);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      sv_lo[i] = 1'b0; sv_hi[i] = 1'b0; sm_lo[i] = 1'b0; sm_hi[i] = 1'b0;
      sd_lo[i] = '0; sd_hi[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(rd_ready0 == 1'b0, "R1 u0 in reset", 64'(rd_ready0), 64'd0);
    chk(rd_ready1 == 1'b0, "R1 u1 in reset", 64'(rd_ready1), 64'd0);
    rst_n = 1'b1;
    idle(4);
    chk(rd_ready0 == 1'b0, "R1 u0 after reset", 64'(rd_ready0), 64'd0);
    chk(rd_ready1 == 1'b0, "R1 u1 after reset", 64'(rd_ready1), 64'd0);

    for (int c = 1; c <= 2; c++) begin
      for (int f = 0; f <= 1; f++) begin
        int n, d, L;
        lat_coarse = CW'(c);
        lat_fine = f[0];
        L = 2 * c + f;
        // R7/R2: exact cycle of rd_ready for a lone read into an empty queue
        n = cyc + 1;
        step(1'b1, 1'b0);
        d = n + (L + BL - 1) / 2;
        while (cyc < d - 1) step(1'b0, 1'b0);
        chk(rd_ready0 == 1'b0, "R7 u0 early", 64'(rd_ready0), 64'd0);
        chk(rd_ready1 == 1'b0, "R7 u1 early", 64'(rd_ready1), 64'd0);
        step(1'b0, 1'b0);
        chk(rd_ready0 == 1'b1, "R7 u0 rise", 64'(rd_ready0), 64'd1);
        chk(rd_ready1 == 1'b1, "R7 u1 rise", 64'(rd_ready1), 64'd1);
        idle(2);
        drain();
        // R2/R3/R4/R8: spacings that make beats contiguous or leave junk between bursts
        run_reads(4, 2, 1'b0); drain();
        run_reads(4, 3, 1'b0); drain();
        run_reads(4, 5, 1'b0); drain();
        // R10: fifth word arrives into a full queue
        run_reads(5, 2, 1'b0); drain();
        // R6: memory valid withheld; u1 must stay empty, u0 still captures (R4)
        run_reads(1, 2, 1'b1);
        chk(rd_ready1 == 1'b0, "R6 u1 no word", 64'(rd_ready1), 64'd0);
        drain();
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    w = 0;
    while (!done) begin
      @(posedge clk);
      w++;
      if (w > 100000 && !done) begin
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=finished", w);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

endmodule